// File: doc/BRIEF.md
# Music Event Queue with Low-Water Interrupt

This block is a first-in first-out store of 16-bit music event words, 32 entries deep. A host register interface pushes words in and a playback sequencer reads the oldest word and pops it once it has finished with it. The buffer itself keeps no record of what a word means.

To keep playback fed without the host polling it, the block drives an active-low interrupt request. The request goes low when the number of stored words is at or below a programmable 5-bit threshold and the request is enabled. The host answers by writing more words. Three flush inputs empty the queue: a stop command from the sequencer control, a level-sensitive digital power-down, and a soft reset. Only the soft reset also clears the sticky overflow flag.

Top module: `score_queue`

## Requirements
- R1: After reset `level` is 0, `empty` is 1, `full` is 0, `overflow` is 0, `irq_n` is 1 and `rd_data` is 0.
- R2: Accepted words come out in the order they were written. `rd_data` shows the oldest stored word while the queue is not empty and shows 0 while it is empty. A pop at a clock edge removes that word.
- R3: A write while 32 words are stored, with no pop in the same cycle, is dropped. Level and contents stay the same and `overflow` goes to 1. `overflow` then stays 1 until reset or `soft_clr`.
- R4: A pop while the queue is empty is ignored. The level stays 0 and later writes read back intact.
- R5: A push and a pop in the same cycle leave the level unchanged and keep the order. This holds when the queue is full, where both are accepted. When the queue is empty only the push takes effect.
- R6: `irq_n` is registered. After a clock edge it is 0 when `irq_en` was 1 at that edge and the new level is at or below `irq_thr`. `irq_thr` ranges from 0 (empty) to 31 (one free slot).
- R7: `irq_n` returns to 1 at the first edge where `irq_en` is 0 or the new level exceeds `irq_thr`.
- R8: A cycle with `stop_req` = 1 leaves the queue empty after the edge. Any push or pop in that cycle is discarded, and `overflow` is kept.
- R9: While `dig_pd` = 1 the queue is held empty, writes are dropped without setting `overflow`, and the queue is empty when power-down ends.
- R10: A cycle with `soft_clr` = 1 empties the queue and clears `overflow`.
- R11: `empty` is 1 exactly when `level` is 0, and `full` is 1 exactly when `level` is 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` at this edge |
| wr_data | input | 16 | Event word to store |
| rd_pop | input | 1 | Remove the oldest word at this edge |
| irq_en | input | 1 | Interrupt enable, 1 enables |
| irq_thr | input | 5 | Low-water threshold, 0 to 31 |
| stop_req | input | 1 | Playback stop, flushes the queue |
| dig_pd | input | 1 | Digital power-down, level, flushes the queue |
| soft_clr | input | 1 | Soft reset, flushes the queue and clears `overflow` |
| rd_data | output | 16 | Oldest stored word, 0 when empty |
| level | output | 6 | Number of stored words |
| empty | output | 1 | Queue holds no word |
| full | output | 1 | Queue holds 32 words |
| overflow | output | 1 | Sticky flag for a dropped write |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench fills the queue to the brim and pushes once more. A design that overwrote the oldest slot would show a changed head word, and one that wrapped its counter would report an empty queue. It pushes and pops together at the empty, middle and full boundaries. A design that refused a push at full would lose a word, and one that popped from nothing would read stale data. It sweeps the level across a threshold in both directions and toggles the enable, which exposes an off-by-one compare or a request that lags a cycle. It also pushes in the very cycle of each flush, so a flush with the wrong priority leaves a word behind.

// File: rtl/sq_pkg.sv
package sq_pkg;
    // Per-cycle request bundle handed from the top to the queue control
    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
        logic clr;
    } sq_cmd_t;
endpackage

// File: rtl/sq_storage.sv
module sq_storage #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl
    import sq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sq_cmd_t       cmd,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt,
    output logic          push_ok,
    output logic          overflow
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          ovf;
    } state_t;

    state_t s_d, s_q;
    logic   pop_ok_d, push_ok_d;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d       = s_q;
        pop_ok_d  = cmd.pop && (s_q.count != '0);
        push_ok_d = cmd.push && ((s_q.count != CW'(DEPTH)) || pop_ok_d);
        if (cmd.flush) begin
            // flush wins over any push or pop in the same cycle
            push_ok_d  = 1'b0;
            pop_ok_d   = 1'b0;
            s_d.wr_ptr = '0;
            s_d.rd_ptr = '0;
            s_d.count  = '0;
            if (cmd.clr) begin
                s_d.ovf = 1'b0;
            end
        end else begin
            if (push_ok_d) begin
                s_d.wr_ptr = ptr_inc(s_q.wr_ptr);
            end
            if (pop_ok_d) begin
                s_d.rd_ptr = ptr_inc(s_q.rd_ptr);
            end
            s_d.count = s_q.count + CW'(push_ok_d) - CW'(pop_ok_d);
            if (cmd.push && !push_ok_d) begin
                s_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_ptr    = s_q.wr_ptr;
    assign rd_ptr    = s_q.rd_ptr;
    assign count     = s_q.count;
    assign count_nxt = s_d.count;
    assign push_ok   = push_ok_d;
    assign overflow  = s_q.ovf;
endmodule

// File: rtl/sq_irq.sv
module sq_irq #(
    parameter int CW = 6,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_en,
    input  logic [TW-1:0] thr,
    input  logic [CW-1:0] count_nxt,
    output logic          irq_n
);
    logic irq_n_d, irq_n_q;

    // compare against the level that the edge is about to store
    always_comb begin
        irq_n_d = !(irq_en && (count_nxt <= CW'(thr)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_n_q <= 1'b1;
        end else begin
            irq_n_q <= irq_n_d;
        end
    end

    assign irq_n = irq_n_q;
endmodule

// File: rtl/score_queue.sv
module score_queue
    import sq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_pop,
    input  logic             irq_en,
    input  logic [AW-1:0]    irq_thr,
    input  logic             stop_req,
    input  logic             dig_pd,
    input  logic             soft_clr,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    level,
    output logic             empty,
    output logic             full,
    output logic             overflow,
    output logic             irq_n
);
    sq_cmd_t          cmd;
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count, count_nxt;
    logic             push_ok;
    logic [WIDTH-1:0] head;

    always_comb begin
        cmd.push  = wr_en;
        cmd.pop   = rd_pop;
        cmd.flush = stop_req || dig_pd || soft_clr;
        cmd.clr   = soft_clr;
    end

    sq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .count     (count),
        .count_nxt (count_nxt),
        .push_ok   (push_ok),
        .overflow  (overflow)
    );

    sq_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk   (clk),
        .we    (push_ok),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (head)
    );

    sq_irq #(.CW(CW), .TW(AW)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_en    (irq_en),
        .thr       (irq_thr),
        .count_nxt (count_nxt),
        .irq_n     (irq_n)
    );

    assign level   = count;
    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign rd_data = empty ? '0 : head;
endmodule

// File: rtl/score_queue_chk.sv
module score_queue_chk #(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_pop,
    input logic          irq_en,
    input logic          stop_req,
    input logic          dig_pd,
    input logic          soft_clr,
    input logic [CW-1:0] level,
    input logic          empty,
    input logic          full,
    input logic          overflow,
    input logic          irq_n
);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !soft_clr) |=> overflow);

    a_r4_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_pop && !wr_en) |=> empty);

    a_r5_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && wr_en && rd_pop && !stop_req && !dig_pd && !soft_clr) |=> $stable(level));

    a_r7_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> irq_n);

    a_r8_stop_flush: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> empty);

    a_r9_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_pd && !overflow) |=> (empty && !overflow));

    a_r10_soft_clr: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (empty && !overflow));

    a_r11_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (level == '0)) && (full == (level == CW'(DEPTH))));
endmodule

bind score_queue score_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_pop   (rd_pop),
    .irq_en   (irq_en),
    .stop_req (stop_req),
    .dig_pd   (dig_pd),
    .soft_clr (soft_clr),
    .level    (level),
    .empty    (empty),
    .full     (full),
    .overflow (overflow),
    .irq_n    (irq_n)
);

// File: tb/test_score_queue.sv
`timescale 1ns/1ps
module test_score_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_pop = 1'b0;
    logic        irq_en = 1'b0;
    logic [4:0]  irq_thr = '0;
    logic        stop_req = 1'b0;
    logic        dig_pd = 1'b0;
    logic        soft_clr = 1'b0;
    logic [15:0] rd_data;
    logic [5:0]  level;
    logic        empty, full, overflow, irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    logic [15:0] q[$];
    bit          m_ovf = 1'b0;
    bit          m_irq_n = 1'b1;

    always #4 clk = ~clk;

    score_queue i_score_queue (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_pop(rd_pop),
        .irq_en(irq_en), .irq_thr(irq_thr), .stop_req(stop_req), .dig_pd(dig_pd),
        .soft_clr(soft_clr), .rd_data(rd_data), .level(level), .empty(empty),
        .full(full), .overflow(overflow), .irq_n(irq_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare();
        int sz = q.size();
        chk(cur_req, "level", int'(level), sz);
        chk(cur_req, "rd_data", int'(rd_data), (sz > 0) ? int'(q[0]) : 0);
        chk(cur_req, "overflow", int'(overflow), int'(m_ovf));
        chk(cur_req, "irq_n", int'(irq_n), int'(m_irq_n));
        chk("R11", "empty", int'(empty), int'(sz == 0));
        chk("R11", "full", int'(full), int'(sz == 32));
    endtask

    task automatic model_update();
        bit pop_ok, push_ok;
        if (stop_req || dig_pd || soft_clr) begin
            q.delete();
            if (soft_clr) m_ovf = 1'b0;
        end else begin
            pop_ok  = rd_pop && (q.size() > 0);
            push_ok = wr_en && ((q.size() < 32) || pop_ok);
            if (wr_en && !push_ok) m_ovf = 1'b1;
            if (pop_ok) void'(q.pop_front());
            if (push_ok) q.push_back(wr_data);
        end
        m_irq_n = !(irq_en && (q.size() <= int'(irq_thr)));
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        wr_en = 0; rd_pop = 0; stop_req = 0; dig_pd = 0; soft_clr = 0;
    endtask

    task automatic push(input logic [15:0] d);
        idle(); wr_en = 1; wr_data = d; tick(); idle();
    endtask

    task automatic pop();
        idle(); rd_pop = 1; tick(); idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        compare();

        // R2: order under a short burst
        cur_req = "R2";
        for (int i = 0; i < 5; i++) push(16'h1000 + 16'(i * 7));
        for (int i = 0; i < 5; i++) pop();

        // R3: fill, extra write dropped, sticky flag
        cur_req = "R3";
        for (int i = 0; i < 32; i++) push(16'hA000 ^ 16'(i * 97));
        push(16'hDEAD);
        push(16'hBEEF);
        tick();
        // R5: push and pop together while full
        cur_req = "R5";
        idle(); wr_en = 1; rd_pop = 1; wr_data = 16'h5A5A; tick(); idle();
        cur_req = "R2";
        for (int i = 0; i < 32; i++) pop();

        // R4: pop from empty
        cur_req = "R4";
        pop(); pop();
        push(16'h0042);
        pop();

        // R5: at empty only the push lands; then mid-level streaming
        cur_req = "R5";
        idle(); wr_en = 1; rd_pop = 1; wr_data = 16'h7777; tick();
        for (int i = 0; i < 6; i++) begin
            wr_data = 16'h2000 + 16'(i); tick();
        end
        idle();
        push(16'h3333);
        for (int i = 0; i < 3; i++) begin
            idle(); wr_en = 1; rd_pop = 1; wr_data = 16'h4400 + 16'(i); tick();
        end
        idle();

        // R10: soft clear drops data and overflow
        cur_req = "R10";
        idle(); soft_clr = 1; wr_en = 1; wr_data = 16'hFFFF; tick(); idle();
        tick();

        // R6: threshold crossing downward and at the edge
        cur_req = "R6";
        irq_en = 1; irq_thr = 5'd3;
        tick();
        for (int i = 0; i < 6; i++) push(16'h6000 + 16'(i));
        for (int i = 0; i < 4; i++) pop();
        // R7: rising above threshold, then enable cleared
        cur_req = "R7";
        push(16'h6100); push(16'h6101);
        pop(); pop();
        irq_en = 0; tick();
        irq_en = 1; tick();
        irq_thr = 5'd31; cur_req = "R6";
        for (int i = 0; i < 30; i++) push(16'h6200 + 16'(i));
        cur_req = "R7";
        push(16'h62FF);
        irq_thr = 5'd0;
        tick();

        // R8: stop flush with a push in the same cycle, overflow kept
        cur_req = "R8";
        push(16'h0BAD);
        idle(); stop_req = 1; wr_en = 1; wr_data = 16'h0C0C; tick(); idle();
        tick();
        push(16'h0D0D);
        pop();

        // R9: power-down clears and drops writes without overflow
        cur_req = "R9";
        idle(); soft_clr = 1; tick(); idle();
        push(16'h0E01); push(16'h0E02);
        dig_pd = 1;
        for (int i = 0; i < 4; i++) begin
            wr_en = 1; wr_data = 16'h0F00 + 16'(i); tick();
        end
        idle();
        tick();
        push(16'h0E03);
        pop();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule